// File: doc/BRIEF.md
# LED String Fault Supervisor

This block supervises six LED current-sink strings on the digital side of a backlight driver. Each clock it receives, for every string, two comparator results: the sink has reached its target current, and the pin voltage is above the short threshold. It also receives the dimming PWM input, a global output-overvoltage flag and a warm (lower thermal threshold) flag. From these it decides which strings are faulty and switches them off after a time-out. It also raises a sticky active-low fault flag and names the string that the boost regulator should use for headroom feedback.

A string is marked good once it regulates during a dimming on-time. A good string that later loses regulation is treated as open. A string that has never been good is treated as open only while overvoltage or the warm flag is present. A string whose pin is above the short threshold is treated as shorted. A string whose fault persists is disabled after six counted dimming periods, or after a fixed 800 µs of faulty on-time while warm. Fault evaluation is suspended while the dimming input is low. Dropping the enable input clears all supervision state.

Top module: `led_string_supervisor`

## Requirements
- R1: While `enable` is low, every bit of `ch_en` is 0. After `enable` has been sampled low, `fault_n` is 1 and all strings, good marks and counters are cleared. After reset with `enable` high, all `ch_en` bits are 1 and `fault_n` is 1.
- R2: A string that has been good and then has `reg_ok` low at the rising clock edge where `pwm_in` first goes high, in 6 consecutive dimming periods, has its `ch_en` bit cleared after the edge that samples the 6th such rising edge. It is still enabled after 5 such periods, and other strings are unaffected.
- R3: A string that has never reached regulation is not disabled while `ovp_hit` and `warm_hit` are both low.
- R4: While `ovp_hit` is high, a not-yet-good string with `reg_ok` low is treated as open and is disabled after 6 faulty dimming periods. Strings already marked good are not affected.
- R5: A string with `short_hi` high during on-time is disabled after 6 faulty dimming periods, whether or not it is good.
- R6: While `warm_hit` is high, a faulty string is disabled once its fault has been sampled on `WARM_CYC` consecutive on-time clock edges (CLK_HZ×800/10^6). The 6-period limit still applies as well.
- R7: If a string's fault is absent for one clock edge during on-time, its time-out counts restart from zero.
- R8: Conditions present only while `pwm_in` is low neither disable a string nor raise the fault flag (except overvoltage, see R9). Counts are held across off-time.
- R9: `fault_n` goes low in the same cycle a string is disabled, or after any edge sampling `ovp_hit` high with `enable` high. It stays low, and disabled strings stay disabled, until `enable` is sampled low.
- R10: `fb_sel` is the index of the lowest `ch_level` among strings with `ch_en` 1 and `short_hi` 0, with ties going to the lower index. `fb_valid` is 0 when no string qualifies. The selection responds combinationally.
- R11: A disabled string is never selected by `fb_sel`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Block enable; low clears all supervision state |
| pwm_in | input | 1 | Dimming PWM; high is on-time |
| ovp_hit | input | 1 | Output overvoltage reached |
| warm_hit | input | 1 | Lower thermal threshold active |
| reg_ok | input | NUM_CH | Per-string target current reached |
| short_hi | input | NUM_CH | Per-string pin above short threshold |
| ch_level | input | NUM_CH*LVL_W | Per-string digitized pin voltage, string i at bits [i*LVL_W +: LVL_W] |
| ch_en | output | NUM_CH | Per-string sink enable |
| fault_n | output | 1 | Sticky fault flag, active low |
| fb_sel | output | SEL_W | Index of headroom feedback string |
| fb_valid | output | 1 | A feedback string is available |

## Verification
An open fault is driven in three forms: loss of regulation after a string has been good, a never-good string under overvoltage, and a never-good string under the warm flag. Together these separate the good-mark tracking from the forced reclassification, and the period-based time-out from the fixed cycle time-out. A shorted string, a fault that clears for a single period, and a fault present only during off-time show whether the counter restarts and whether on-time gating is applied. Level patterns with ties, with shorted candidates, with a disabled lowest string and with no candidates at all show the tie rule and the exclusion rules of the feedback selector.

// File: rtl/led_sup_pkg.sv
package led_sup_pkg;

    typedef enum logic [1:0] {
        FK_NONE   = 2'd0,
        FK_SHORT  = 2'd1,
        FK_OPEN   = 2'd2,
        FK_FORCED = 2'd3
    } fault_kind_e;

    // Global state of the supervisor top
    typedef struct packed {
        logic pwm_prev;
        logic flag;
    } top_state_t;

    // Classify one string's condition for the current clock
    function automatic fault_kind_e classify(input logic pwm_on,
                                             input logic short_hi,
                                             input logic good,
                                             input logic reg_ok,
                                             input logic stress);
        if (!pwm_on)                      return FK_NONE;
        if (short_hi)                     return FK_SHORT;
        if (good && !reg_ok)              return FK_OPEN;
        if (!good && !reg_ok && stress)   return FK_FORCED;
        return FK_NONE;
    endfunction

endpackage

// File: rtl/led_sup_channel.sv
module led_sup_channel
    import led_sup_pkg::*;
#(
    parameter int PWM_LIMIT = 6,
    parameter int WARM_CYC  = 200000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic pwm_on,
    input  logic pwm_rise,
    input  logic stress,
    input  logic warm,
    input  logic reg_ok,
    input  logic short_hi,
    output logic ch_en,
    output logic trip
);

    localparam int EW = $clog2(PWM_LIMIT + 1);
    localparam int CW = $clog2(WARM_CYC + 1);

    typedef struct packed {
        logic          good;
        logic          dis;
        logic [EW-1:0] edges;
        logic [CW-1:0] cyc;
    } ch_state_t;

    ch_state_t   st_d, st_q;
    fault_kind_e kind;

    always_comb begin
        st_d = st_q;
        trip = 1'b0;
        kind = classify(pwm_on, short_hi, st_q.good, reg_ok, stress);
        if (!enable) begin
            st_d = '0;
        end else if (!st_q.dis && pwm_on) begin
            if (reg_ok && !short_hi) begin
                st_d.good = 1'b1;
            end
            if (kind == FK_NONE) begin
                st_d.edges = '0;
                st_d.cyc   = '0;
            end else begin
                if (pwm_rise && (st_q.edges < EW'(PWM_LIMIT))) begin
                    st_d.edges = st_q.edges + 1'b1;
                end
                if (st_q.cyc < CW'(WARM_CYC)) begin
                    st_d.cyc = st_q.cyc + 1'b1;
                end
                if ((st_d.edges >= EW'(PWM_LIMIT)) ||
                    (warm && (st_d.cyc >= CW'(WARM_CYC)))) begin
                    st_d.dis = 1'b1;
                    trip     = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ch_en = enable && !st_q.dis;

endmodule

// File: rtl/led_sup_lowest.sv
module led_sup_lowest #(
    parameter int N     = 6,
    parameter int LW    = 8,
    parameter int SW    = 3
) (
    input  logic [N*LW-1:0] level,
    input  logic [N-1:0]    cand,
    output logic [SW-1:0]   sel,
    output logic            valid
);

    logic [LW-1:0] best;
    logic          found;

    always_comb begin
        best  = '0;
        found = 1'b0;
        sel   = '0;
        for (int i = 0; i < N; i++) begin
            if (cand[i] && (!found || (level[i*LW +: LW] < best))) begin
                best  = level[i*LW +: LW];
                found = 1'b1;
                sel   = SW'(i);
            end
        end
        valid = found;
    end

endmodule

// File: rtl/led_string_supervisor.sv
module led_string_supervisor
    import led_sup_pkg::*;
#(
    parameter int  NUM_CH    = 6,
    parameter int  LVL_W     = 8,
    parameter int  PWM_LIMIT = 6,
    parameter int  CLK_HZ    = 250_000_000,
    parameter int  WARM_US   = 800,
    localparam int SEL_W     = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    enable,
    input  logic                    pwm_in,
    input  logic                    ovp_hit,
    input  logic                    warm_hit,
    input  logic [NUM_CH-1:0]       reg_ok,
    input  logic [NUM_CH-1:0]       short_hi,
    input  logic [NUM_CH*LVL_W-1:0] ch_level,
    output logic [NUM_CH-1:0]       ch_en,
    output logic                    fault_n,
    output logic [SEL_W-1:0]        fb_sel,
    output logic                    fb_valid
);

    localparam int WARM_CYC = int'((longint'(CLK_HZ) * longint'(WARM_US)) / 64'd1_000_000);

    top_state_t        top_d, top_q;
    logic [NUM_CH-1:0] trip;
    logic              pwm_rise;
    logic              stress;

    assign pwm_rise = pwm_in && !top_q.pwm_prev;
    assign stress   = ovp_hit || warm_hit;

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        led_sup_channel #(
            .PWM_LIMIT (PWM_LIMIT),
            .WARM_CYC  (WARM_CYC)
        ) u_ch (
            .clk      (clk),
            .rst_n    (rst_n),
            .enable   (enable),
            .pwm_on   (pwm_in),
            .pwm_rise (pwm_rise),
            .stress   (stress),
            .warm     (warm_hit),
            .reg_ok   (reg_ok[g]),
            .short_hi (short_hi[g]),
            .ch_en    (ch_en[g]),
            .trip     (trip[g])
        );
    end

    always_comb begin
        top_d          = top_q;
        top_d.pwm_prev = pwm_in;
        if (!enable) begin
            top_d.flag = 1'b0;
        end else if ((|trip) || ovp_hit) begin
            top_d.flag = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            top_q <= '0;
        end else begin
            top_q <= top_d;
        end
    end

    assign fault_n = !top_q.flag;

    led_sup_lowest #(
        .N  (NUM_CH),
        .LW (LVL_W),
        .SW (SEL_W)
    ) u_low (
        .level (ch_level),
        .cand  (ch_en & ~short_hi),
        .sel   (fb_sel),
        .valid (fb_valid)
    );

endmodule

// File: rtl/led_sup_chk.sv
module led_sup_chk #(
    parameter int NUM_CH = 6,
    parameter int SEL_W  = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              enable,
    input logic              pwm_in,
    input logic [NUM_CH-1:0] short_hi,
    input logic [NUM_CH-1:0] ch_en,
    input logic              fault_n,
    input logic [SEL_W-1:0]  fb_sel,
    input logic              fb_valid
);

    logic [NUM_CH-1:0] cand;
    assign cand = ch_en & ~short_hi;

    // R1
    off_when_disabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |-> (ch_en == '0));

    // R9
    flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!fault_n && enable) |=> !fault_n);

    // R9
    no_reenable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && $past(enable)) |-> ((ch_en & ~$past(ch_en)) == '0));

    // R9
    drop_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && $past(enable) && ((~ch_en & $past(ch_en)) != '0)) |-> !fault_n);

    // R8
    drop_in_ontime_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && $past(enable) && ((~ch_en & $past(ch_en)) != '0)) |-> $past(pwm_in));

    // R10
    sel_candidate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fb_valid |-> (((cand >> fb_sel) & NUM_CH'(1)) != '0));

    // R10
    no_valid_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !fb_valid |-> (cand == '0));

endmodule

bind led_string_supervisor led_sup_chk #(
    .NUM_CH (NUM_CH),
    .SEL_W  (SEL_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .enable   (enable),
    .pwm_in   (pwm_in),
    .short_hi (short_hi),
    .ch_en    (ch_en),
    .fault_n  (fault_n),
    .fb_sel   (fb_sel),
    .fb_valid (fb_valid)
);

// File: tb/led_string_supervisor_tb.sv
`timescale 1ns/1ps
module led_string_supervisor_tb;

    localparam int N    = 6;
    localparam int LW   = 8;
    localparam int HZ   = 50_000;
    localparam int WARM = 40;   // 50 kHz * 800 us

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           enable = 1'b1;
    logic           pwm_in = 1'b0;
    logic           ovp_hit = 1'b0;
    logic           warm_hit = 1'b0;
    logic [N-1:0]   reg_ok = '0;
    logic [N-1:0]   short_hi = '0;
    logic [N*LW-1:0] ch_level = '0;
    logic [N-1:0]   ch_en;
    logic           fault_n;
    logic [2:0]     fb_sel;
    logic           fb_valid;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    led_string_supervisor #(.NUM_CH(N), .LVL_W(LW), .CLK_HZ(HZ)) u_dut (
        .clk(clk), .rst_n(rst_n), .enable(enable), .pwm_in(pwm_in),
        .ovp_hit(ovp_hit), .warm_hit(warm_hit), .reg_ok(reg_ok),
        .short_hi(short_hi), .ch_level(ch_level), .ch_en(ch_en),
        .fault_n(fault_n), .fb_sel(fb_sel), .fb_valid(fb_valid)
    );

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic step(int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic periods(int n);
        for (int i = 0; i < n; i++) begin
            pwm_in = 1'b1; step(4);
            pwm_in = 1'b0; step(4);
        end
    endtask

    task automatic restart();
        ovp_hit = 0; warm_hit = 0; short_hi = '0; reg_ok = '1; pwm_in = 0;
        enable = 1'b0; step(2);
        check("R1 ch_en while enable low", ch_en, 0);
        check("R1 fault_n after enable low", fault_n, 1);
        enable = 1'b1; step(1);
    endtask

    task automatic t_reset();
        step(1);
        rst_n = 1'b1; step(1);
        check("R1 reset ch_en", ch_en, 6'h3f);
        check("R1 reset fault_n", fault_n, 1);
    endtask

    task automatic t_lost_reg();
        restart(); periods(1);
        reg_ok[1] = 1'b0; periods(5);
        check("R2 still on after 5", ch_en, 6'h3f);
        check("R2 no flag yet", fault_n, 1);
        periods(1);
        check("R2 off after 6", ch_en, 6'h3d);
        check("R9 flag on disable", fault_n, 0);
        // R11: disabled string with lowest level is not chosen
        for (int i = 0; i < N; i++) ch_level[i*LW +: LW] = 8'd100;
        ch_level[1*LW +: LW] = 8'd5; step(1);
        check("R11 disabled not selected", fb_sel, 0);
        reg_ok[1] = 1'b1; periods(3);
        check("R9 stays disabled", ch_en, 6'h3d);
        check("R9 flag stays low", fault_n, 0);
        restart();
        check("R9 cleared by re-enable", {26'd0, fault_n, ch_en}, 32'h7f);
    endtask

    task automatic t_never_good();
        restart(); reg_ok[2] = 1'b0; periods(10);
        check("R3 never-good kept on", ch_en, 6'h3f);
        check("R3 no flag", fault_n, 1);
    endtask

    task automatic t_ovp();
        restart(); reg_ok[3] = 1'b0; periods(1);
        ovp_hit = 1'b1; periods(1);
        check("R9 flag on ovp", fault_n, 0);
        periods(4);
        check("R4 on after 5", ch_en, 6'h3f);
        periods(1);
        check("R4 forced open off after 6", ch_en, 6'h37);
        ovp_hit = 1'b0;
    endtask

    task automatic t_short();
        restart(); periods(1);
        short_hi[4] = 1'b1; periods(5);
        check("R5 on after 5", ch_en, 6'h3f);
        periods(1);
        check("R5 short off after 6", ch_en, 6'h2f);
    endtask

    task automatic t_warm();
        restart(); reg_ok[5] = 1'b0; periods(1);
        warm_hit = 1'b1; pwm_in = 1'b1;
        step(WARM - 1);
        check("R6 on before warm limit", ch_en, 6'h3f);
        step(1);
        check("R6 off at warm limit", ch_en, 6'h1f);
        pwm_in = 1'b0; warm_hit = 1'b0; step(2);
    endtask

    task automatic t_clear();
        restart(); periods(1);
        reg_ok[0] = 1'b0; periods(5);
        reg_ok[0] = 1'b1; periods(1);
        reg_ok[0] = 1'b0; periods(5);
        check("R7 restarted count", ch_en, 6'h3f);
        periods(1);
        check("R7 off after fresh 6", ch_en, 6'h3e);
    endtask

    task automatic t_offtime();
        restart(); periods(1);
        for (int i = 0; i < 10; i++) begin
            pwm_in = 1'b1; reg_ok[1] = 1'b1; short_hi[2] = 1'b0; step(4);
            pwm_in = 1'b0; reg_ok[1] = 1'b0; short_hi[2] = 1'b1; step(4);
        end
        reg_ok = '1; short_hi = '0; step(1);
        check("R8 off-time faults ignored", ch_en, 6'h3f);
        check("R8 no flag", fault_n, 1);
    endtask

    task automatic t_select();
        restart();
        ch_level = {8'd20, 8'd90, 8'd30, 8'd70, 8'd30, 8'd50};
        short_hi = 6'b100000; step(1);
        check("R10 tie to lower index", fb_sel, 1);
        check("R10 valid", fb_valid, 1);
        short_hi = '0; step(1);
        check("R10 lowest", fb_sel, 5);
        short_hi = '1; step(1);
        check("R10 none valid", fb_valid, 0);
        short_hi = '0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=running expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        t_reset();
        t_lost_reg();
        t_never_good();
        t_ovp();
        t_short();
        t_warm();
        t_clear();
        t_offtime();
        t_select();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule